// File: doc/BRIEF.md
# Datapath Tap Injection and Capture Harness

This debug block sits across a set of datapath buses called taps. Each tap has an input bus and an output bus. Normally every output copies its input. The host controls the block through three word-wide registers. It can replace the traffic on one tap with words it has loaded into a transmit FIFO. It can also record the traffic seen on one tap into a receive FIFO and read that record back later.

Injection happens in two steps. The host first pushes words into the transmit FIFO through the TX data register. It then writes a nonzero tap number into the TX select field of the control register. From the next cycle the selected tap's output carries the FIFO head, and one word leaves the FIFO per clock. When the last word has gone, the selection clears itself and the tap returns to pass-through.

Capture works continuously. While a receive tap is selected, the value on that tap's output is appended to the receive FIFO every cycle. This is the value after any substitution. When the receive FIFO is full, its oldest entry is dropped, so it always holds the most recent `RX_DEPTH` words.

Two small state machines control the block:
- The injection controller has the states `INJ_IDLE` and `INJ_RUN`.
  - arm: `INJ_IDLE` to `INJ_RUN`, on a legal nonzero TX select write while the FIFO is not empty.
  - abort: `INJ_RUN` to `INJ_IDLE`, on a write of TX select 0.
  - drain: `INJ_RUN` to `INJ_IDLE`, when the last word is being popped and no push arrives in the same cycle.
  - retarget: stays in `INJ_RUN`, on any other control write.
- The capture controller has the states `CAP_OFF` and `CAP_ON`.
  - start and retarget: any control write with a nonzero legal RX select leads to `CAP_ON`.
  - stop: a write with RX select 0 leads to `CAP_OFF`.

Top module: `tap_harness`

## Requirements
- R1: After reset, every tap output equals its input, both FIFOs are empty and the control register reads 0.
- R2: Register addresses are 0 for control, 1 for TX data and 2 for RX data.
  - A write to address 1 pushes a word into the TX FIFO; a read of address 2 pops the RX FIFO.
  - A control read returns TX select in bits [7:0], RX select in bits [15:8], the TX FIFO level in bits [23:16], the RX FIFO level in bits [30:24] and the sticky underflow flag in bit 31.
  - Reads of address 3 return 0, and reg_rdata is 0 when no read is requested.
- R3: A control write whose bits [7:0] hold a tap number k (1 to NUM_TAPS), made while the TX FIFO holds data, arms injection.
  - From the next cycle, tap k-1's output carries the FIFO words in push order, one per cycle.
  - All other taps pass their inputs through.
- R4: In the cycle after the last TX word is injected, the TX select field reads 0 and every tap passes through.
- R5: A nonzero TX select written while the TX FIFO is empty is refused: the select stays 0 and nothing is injected.
- R6: Words pushed during injection are appended to the injected stream. A push to a full TX FIFO that is not being popped is dropped.
- R7: Writing TX select 0 while armed stops injection at once. The words not yet injected stay in the TX FIFO.
- R8: While RX select holds a tap number k, the value on tap k-1's output, after substitution, is appended to the RX FIFO every cycle.
- R9: When the RX FIFO is full and capture is on, the oldest entry is discarded, so reads return the last RX_DEPTH captured words, oldest first.
- R10: Underflow handling:
  - Reading RX data while the RX FIFO is empty returns 0 and sets bit 31 of the control register.
  - The bit stays set until a control write with bit 31 set clears it.
- R11: Select field values greater than NUM_TAPS are treated as 0, for both TX and RX select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (an RX data read pops the FIFO at the clock edge) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the current state |
| tap_in | input | NUM_TAPS x DATA_W | Tap input buses |
| tap_out | output | NUM_TAPS x DATA_W | Tap output buses after substitution |

## Verification
The embedded assertions check four things on every cycle:
- At most one tap is ever substituted.
- Injection is never armed while the TX FIFO is empty, and it cannot leave the idle state while that FIFO stays empty.
- A full RX FIFO that captures without being read stays full.
- The underflow flag only falls on an explicit clear.

Only the bench scenarios can show the word order of the injected stream, how late pushes extend it, and the result of an abort. The same holds for the exact window kept after the RX FIFO wraps and for the handling of out-of-range selects. The bench compares each of these against a cycle-level reference model.

// File: rtl/tap_pkg.sv
package tap_pkg;

    // Register addresses; the host decodes these.
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_TXDATA = 2'd1,
        REG_RXDATA = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    // Control register field positions
    localparam int CTL_TXSEL_LSB = 0;
    localparam int CTL_RXSEL_LSB = 8;
    localparam int CTL_TXLVL_LSB = 16;
    localparam int CTL_RXLVL_LSB = 24;
    localparam int CTL_UNF_BIT   = 31;

    typedef enum logic {
        INJ_IDLE = 1'b0,
        INJ_RUN  = 1'b1
    } inj_state_e;

    typedef enum logic {
        CAP_OFF = 1'b0,
        CAP_ON  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/tap_fifo.sv
module tap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic          do_pop;
    logic          do_push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R6: level never exceeds the depth
    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: a push into a full FIFO without a pop leaves the level unchanged
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/tap_inject_ctl.sv
module tap_inject_ctl
    import tap_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [SEL_W-1:0] new_sel,
    input  logic             fifo_empty,
    input  logic [CW-1:0]    fifo_count,
    input  logic             fifo_push,
    output logic [SEL_W-1:0] sel,
    output logic             pop
);

    inj_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            INJ_IDLE: begin
                if (ctrl_wr && new_sel != '0 && !fifo_empty) begin
                    state_d = INJ_RUN;          // arm
                    sel_d   = new_sel;
                end
            end
            INJ_RUN: begin
                if (ctrl_wr && new_sel == '0) begin
                    state_d = INJ_IDLE;         // abort
                    sel_d   = '0;
                end else if (fifo_count == CW'(1) && !fifo_push) begin
                    state_d = INJ_IDLE;         // drain
                    sel_d   = '0;
                end else if (ctrl_wr) begin
                    sel_d   = new_sel;          // retarget
                end
            end
            default: begin
                state_d = INJ_IDLE;
                sel_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INJ_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        sel = (state_q == INJ_RUN) ? sel_q : '0;
        pop = (state_q == INJ_RUN);
    end

    // R4: injection is never active on an empty FIFO
    assert_run_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_RUN) |-> !fifo_empty);

    // R5: an empty FIFO with no push keeps the controller idle
    assert_empty_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_IDLE && fifo_empty && !fifo_push) |=> (state_q == INJ_IDLE));

endmodule

// File: rtl/tap_capture_ctl.sv
module tap_capture_ctl
    import tap_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [SEL_W-1:0] new_sel,
    output logic [SEL_W-1:0] sel,
    output logic             push
);

    cap_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            CAP_OFF: begin
                if (ctrl_wr && new_sel != '0) begin
                    state_d = CAP_ON;           // start
                    sel_d   = new_sel;
                end
            end
            CAP_ON: begin
                if (ctrl_wr) begin
                    if (new_sel == '0) begin
                        state_d = CAP_OFF;      // stop
                        sel_d   = '0;
                    end else begin
                        sel_d   = new_sel;      // retarget
                    end
                end
            end
            default: begin
                state_d = CAP_OFF;
                sel_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_OFF;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        sel  = (state_q == CAP_ON) ? sel_q : '0;
        push = (state_q == CAP_ON);
    end

endmodule

// File: rtl/tap_harness.sv
module tap_harness
    import tap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_TAPS = 4,
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [1:0]                     reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic [NUM_TAPS-1:0][DATA_W-1:0] tap_in,
    output logic [NUM_TAPS-1:0][DATA_W-1:0] tap_out
);

    localparam int SEL_W = $clog2(NUM_TAPS + 1);
    localparam int TXC_W = $clog2(TX_DEPTH + 1);
    localparam int RXC_W = $clog2(RX_DEPTH + 1);

    // Register decode
    logic              ctrl_wr, tx_push_req, rx_rd;
    logic [7:0]        tx_field, rx_field;
    logic [SEL_W-1:0]  tx_new, rx_new;

    assign ctrl_wr     = reg_wr && (reg_addr == REG_CTRL);
    assign tx_push_req = reg_wr && (reg_addr == REG_TXDATA);
    assign rx_rd       = reg_rd && (reg_addr == REG_RXDATA);
    assign tx_field    = reg_wdata[CTL_TXSEL_LSB +: 8];
    assign rx_field    = reg_wdata[CTL_RXSEL_LSB +: 8];
    assign tx_new      = (tx_field <= 8'(NUM_TAPS)) ? SEL_W'(tx_field) : '0;
    assign rx_new      = (rx_field <= 8'(NUM_TAPS)) ? SEL_W'(rx_field) : '0;

    // TX path
    logic [DATA_W-1:0] tx_head;
    logic [TXC_W-1:0]  tx_count;
    logic              tx_full, tx_empty, tx_pop;
    logic [SEL_W-1:0]  tx_sel;

    tap_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push_req), .pop(tx_pop),
        .wdata(reg_wdata[DATA_W-1:0]),
        .head(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    tap_inject_ctl #(.SEL_W(SEL_W), .CW(TXC_W)) u_inject (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .new_sel(tx_new),
        .fifo_empty(tx_empty), .fifo_count(tx_count),
        .fifo_push(tx_push_req),
        .sel(tx_sel), .pop(tx_pop)
    );

    // Substitution muxes
    logic [NUM_TAPS-1:0] tap_hit;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_hit[i] = (tx_sel == SEL_W'(i + 1));
        assign tap_out[i] = tap_hit[i] ? tx_head : tap_in[i];
    end

    // RX path
    logic [SEL_W-1:0]  rx_sel;
    logic              cap_push;
    logic [DATA_W-1:0] cap_word;
    logic [DATA_W-1:0] rx_head;
    logic [RXC_W-1:0]  rx_count;
    logic              rx_full, rx_empty, host_pop, rx_pop;
    logic              unf_q;

    tap_capture_ctl #(.SEL_W(SEL_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .new_sel(rx_new),
        .sel(rx_sel), .push(cap_push)
    );

    always_comb begin
        cap_word = '0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (rx_sel == SEL_W'(i + 1)) cap_word = tap_out[i];
        end
    end

    assign host_pop = rx_rd && !rx_empty;
    assign rx_pop   = host_pop || (rx_full && cap_push);

    tap_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(cap_push), .pop(rx_pop),
        .wdata(cap_word),
        .head(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                  unf_q <= 1'b0;
        else if (rx_rd && rx_empty)                  unf_q <= 1'b1;
        else if (ctrl_wr && reg_wdata[CTL_UNF_BIT])  unf_q <= 1'b0;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr_e'(reg_addr))
                REG_CTRL: begin
                    reg_rdata[CTL_TXSEL_LSB +: 8] = 8'(tx_sel);
                    reg_rdata[CTL_RXSEL_LSB +: 8] = 8'(rx_sel);
                    reg_rdata[CTL_TXLVL_LSB +: 8] = 8'(tx_count);
                    reg_rdata[CTL_RXLVL_LSB +: 7] = 7'(rx_count);
                    reg_rdata[CTL_UNF_BIT]        = unf_q;
                end
                REG_RXDATA: reg_rdata = rx_empty ? '0 : 32'(rx_head);
                REG_TXDATA: reg_rdata = '0;
                REG_NONE:   reg_rdata = '0;
                default:    reg_rdata = '0;
            endcase
        end
    end

    // R3: at most one tap is substituted
    assert_single_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_hit));

    // R4: a selected injection tap always has FIFO data behind it
    assert_sel_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel != '0) |-> !tx_empty);

    // R9: a full RX FIFO that keeps capturing without a read stays full
    assert_rx_window_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && cap_push && !host_pop) |=> rx_full);

    // R8: a capture cycle leaves the RX FIFO non-empty
    assert_capture_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |=> !rx_empty);

    // R10: the underflow flag falls only on an explicit clear
    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !(ctrl_wr && reg_wdata[CTL_UNF_BIT])) |=> unf_q);

endmodule

// File: tb/tb_tap_harness.sv
module tb_tap_harness;
    import tap_pkg::*;

    localparam int DW  = 32;
    localparam int NT  = 4;
    localparam int TXD = 16;
    localparam int RXD = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                     reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]               reg_addr = 2'd0;
    logic [31:0]              reg_wdata = '0;
    logic [31:0]              reg_rdata;
    logic [NT-1:0][DW-1:0]    tap_in = '0;
    logic [NT-1:0][DW-1:0]    tap_out;

    tap_harness #(.DATA_W(DW), .NUM_TAPS(NT), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tap_in(tap_in), .tap_out(tap_out)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    // Reference model state
    logic [DW-1:0] mtx[$];
    logic [DW-1:0] mrx[$];
    int            mtx_sel = 0;
    int            mrx_sel = 0;
    bit            munf = 0;

    function automatic int legal_sel(input logic [7:0] f);
        return (f <= 8'(NT)) ? int'(f) : 0;
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return {munf, 7'(mrx.size()), 8'(mtx.size()), 8'(mrx_sel), 8'(mtx_sel)};
    endfunction

    function automatic logic [DW-1:0] exp_tap(input int i);
        return (mtx_sel == i + 1) ? mtx[0] : tap_in[i];
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check, update the model, pass the rising edge.
    task automatic cycle(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] wd);
        logic [DW-1:0] cap;
        int            n_rx;
        int            nsel;
        bit            tx_had;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        for (int i = 0; i < NT; i++) tap_in[i] = $urandom;
        #1;
        for (int i = 0; i < NT; i++) check($sformatf("tap_out[%0d]", i), tap_out[i], exp_tap(i));
        if (rd) begin
            if (a == REG_CTRL)        check("ctrl read", reg_rdata, exp_ctrl());
            else if (a == REG_RXDATA) check("rx read", reg_rdata, (mrx.size() == 0) ? 32'h0 : mrx[0]);
            else                      check("unused read", reg_rdata, 32'h0);
        end
        // model update for the coming edge
        cap    = (mrx_sel != 0) ? exp_tap(mrx_sel - 1) : '0;
        tx_had = (mtx.size() > 0);
        n_rx   = mrx.size();
        if (rd && a == REG_RXDATA) begin
            if (n_rx > 0) void'(mrx.pop_front());
            else          munf = 1;
        end
        if (mrx_sel != 0) begin
            if (n_rx == RXD && !(rd && a == REG_RXDATA)) void'(mrx.pop_front());
            mrx.push_back(cap);
        end
        begin
            bit popped;
            popped = (mtx_sel != 0);
            if (popped) void'(mtx.pop_front());
            if (wr && a == REG_TXDATA && ((mtx.size() + (popped ? 1 : 0)) < TXD || popped))
                mtx.push_back(wd);
        end
        if (wr && a == REG_CTRL) begin
            nsel = legal_sel(wd[7:0]);
            if (mtx_sel == 0) mtx_sel = (nsel != 0 && tx_had) ? nsel : 0;
            else if (nsel == 0) mtx_sel = 0;
            else mtx_sel = (mtx.size() == 0) ? 0 : nsel;
            mrx_sel = legal_sel(wd[15:8]);
            if (wd[31]) munf = 0;
        end else if (mtx_sel != 0 && mtx.size() == 0) begin
            mtx_sel = 0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle(0, 0, 2'd0, 32'h0);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        cycle(1, 0, a, d);
    endtask

    task automatic rd_reg(input logic [1:0] a);
        cycle(0, 1, a, 32'h0);
    endtask

    function automatic logic [31:0] ctl(input int txs, input int rxs, input bit clr);
        return {clr, 15'h0, 8'(rxs), 8'(txs)};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        req = "R1";
        idle(2);
        rd_reg(REG_CTRL);

        // R2: register map and level fields
        req = "R2";
        for (int k = 0; k < 5; k++) wr_reg(REG_TXDATA, 32'hA000_0000 + k);
        rd_reg(REG_CTRL);
        rd_reg(2'd3);

        // R3: arm tap 2, stream in order; R4: self-disarm
        req = "R3";
        wr_reg(REG_CTRL, ctl(2, 0, 0));
        idle(4);
        req = "R4";
        idle(2);
        rd_reg(REG_CTRL);

        // R5: arming an empty FIFO is refused
        req = "R5";
        wr_reg(REG_CTRL, ctl(3, 0, 0));
        rd_reg(REG_CTRL);
        idle(2);

        // R6: pushes during injection extend the stream; overfill drops
        req = "R6";
        for (int k = 0; k < 3; k++) wr_reg(REG_TXDATA, 32'hB000_0000 + k);
        wr_reg(REG_CTRL, ctl(1, 0, 0));
        for (int k = 0; k < 3; k++) wr_reg(REG_TXDATA, 32'hB100_0000 + k);
        idle(6);
        rd_reg(REG_CTRL);
        for (int k = 0; k < TXD + 3; k++) wr_reg(REG_TXDATA, 32'hC000_0000 + k);
        rd_reg(REG_CTRL);
        wr_reg(REG_CTRL, ctl(4, 0, 0));
        idle(TXD + 2);
        rd_reg(REG_CTRL);

        // R7: abort leaves remaining words
        req = "R7";
        for (int k = 0; k < 6; k++) wr_reg(REG_TXDATA, 32'hD000_0000 + k);
        wr_reg(REG_CTRL, ctl(3, 0, 0));
        idle(2);
        wr_reg(REG_CTRL, ctl(0, 0, 0));
        rd_reg(REG_CTRL);
        idle(2);
        wr_reg(REG_CTRL, ctl(2, 0, 0));
        idle(5);

        // R11: out-of-range selects
        req = "R11";
        for (int k = 0; k < 2; k++) wr_reg(REG_TXDATA, 32'hE000_0000 + k);
        wr_reg(REG_CTRL, ctl(7, 9, 0));
        rd_reg(REG_CTRL);
        idle(2);
        wr_reg(REG_CTRL, ctl(2, 0, 0));
        idle(3);

        // R8: capture with injection on the captured tap
        req = "R8";
        for (int k = 0; k < 4; k++) wr_reg(REG_TXDATA, 32'hF000_0000 + k);
        wr_reg(REG_CTRL, ctl(1, 1, 0));
        idle(6);
        wr_reg(REG_CTRL, ctl(0, 0, 0));
        rd_reg(REG_CTRL);
        for (int k = 0; k < 10; k++) rd_reg(REG_RXDATA);

        // R9: overwrite keeps the newest window
        req = "R9";
        wr_reg(REG_CTRL, ctl(0, 3, 0));
        idle(RXD + 20);
        wr_reg(REG_CTRL, ctl(0, 0, 0));
        rd_reg(REG_CTRL);
        for (int k = 0; k < RXD; k++) rd_reg(REG_RXDATA);

        // R10: empty read returns zero, sets sticky bit, clear
        req = "R10";
        rd_reg(REG_RXDATA);
        idle(1);
        rd_reg(REG_CTRL);
        wr_reg(REG_CTRL, ctl(0, 0, 0));
        rd_reg(REG_CTRL);
        wr_reg(REG_CTRL, ctl(0, 0, 1));
        rd_reg(REG_CTRL);

        // Random mix over R3, R6, R8, R9, R10
        req = "R8 random";
        for (int k = 0; k < 1500; k++) begin
            int r;
            r = $urandom % 12;
            if (r < 4)       wr_reg(REG_TXDATA, $urandom);
            else if (r == 4) wr_reg(REG_CTRL, ctl($urandom % 6, $urandom % 6, ($urandom % 4) == 0));
            else if (r < 7)  rd_reg(REG_RXDATA);
            else if (r == 7) rd_reg(REG_CTRL);
            else             idle(1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule